// File: doc/BRIEF.md
# Streaming Gradient-Magnitude Edge Detector

This block takes a raster stream of greyscale pixels, one per clock when the valid strobe is high, and returns one edge-strength pixel for every pixel it accepts. The two lines that came before the current one are kept in a pair of on-chip RAM banks. From these, and from the incoming pixel, the block builds a 3x3 neighbourhood for each accepted pixel. Two multiply-accumulate kernels work on that neighbourhood side by side. With the default coefficients, one kernel measures horizontal change and the other measures vertical change. The output is the sum of the magnitudes of the two results, clipped to the pixel range.

Each kernel takes nine coefficients as parameters, one per tap. Loading other values turns the same engine into a smoothing or sharpening filter. The accumulator width is derived from the coefficients, so the worst-case sum cannot overflow. A start-of-frame flag, sent together with the first pixel of a frame, realigns the block at any point in the stream. The output has exactly as many pixels as the input and keeps the same order. Pixels near the top and left edges of a frame come out as zero.

Top module: `edge_prewitt`

## Requirements
- R1: While reset is asserted, and after reset until the first accepted pixel, outValid is 0 and outPix is 0.
- R2: Each accepted pixel produces exactly one output pixel, in input order. Its outValid appears at the fourth rising edge counting the edge that samples the input, whatever the gaps between accepted pixels.
- R3: A cycle with pixValid low is ignored, whatever pixIn and pixSof carry. It produces no output and does not disturb the results of later pixels.
- R4: Number the accepted pixel at row r, column c. Its window holds rows r-2..r and columns c-2..c, with tap index = 3*(row offset) + (column offset) and offset 0 the oldest. The first kernel sum Gx uses coefficients -1,0,+1 across each row by default.
- R5: The second kernel sum Gy uses coefficient -1 on the top row (r-2), 0 on the middle row and +1 on the bottom row (r) by default.
- R6: The output value is |Gx| + |Gy|, saturated to 255.
- R7: The output is 0 whenever r < 2 or c < 2.
- R8: pixSof together with pixValid marks row 0, column 0, even in the middle of a line or frame. outSof is high only on the output of that pixel.
- R9: A line is 256 pixels long. After column 255 the next accepted pixel is column 0 of the next row, and the two RAM banks take alternate rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pixIn | input | 8 | Greyscale input pixel |
| pixValid | input | 1 | pixIn is accepted this cycle |
| pixSof | input | 1 | Accepted pixel is the first of a frame |
| outPix | output | 8 | Edge magnitude |
| outValid | output | 1 | outPix holds a new result |
| outSof | output | 1 | Result belongs to the first pixel of a frame |

## Verification
A column or row counter that drifts shows up as misplaced zero borders, or as wrong values from the first interior pixel of the affected line, within four cycles of the offending input. A swapped RAM bank or a stale line first corrupts row 2, the earliest row whose window reaches into the buffer, so frames with row-dependent content expose it by the third line. A window that shifts on idle cycles, or a pipeline flag that loses step with its data, breaks either the fixed four-edge latency or the one-to-one output count. Runs with random gaps carrying junk data catch both.

// File: rtl/edge_pkg.sv
package edge_pkg;
  // widest column index the strobe bundle can carry
  localparam int COL_FIELD_W = 16;

  // per-pixel strobes handed from the control to the datapath
  typedef struct packed {
    logic                   take;    // pixel accepted this cycle
    logic                   first;   // accepted pixel opens a frame
    logic                   border;  // result must be forced to zero
    logic                   slot;    // RAM bank receiving this row
    logic [COL_FIELD_W-1:0] col;     // column of the accepted pixel
  } strobe_t;
endpackage

// File: rtl/edge_ctrl.sv
module edge_ctrl
  import edge_pkg::*;
#(
  parameter int LINE_LEN = 256,
  parameter int ROW_W    = 12
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    pixValid,
  input  logic    pixSof,
  output strobe_t strobes
);
  localparam int COL_W = $clog2(LINE_LEN);

  logic [COL_W-1:0] colCnt, curCol;
  logic [ROW_W-1:0] rowCnt, curRow;
  logic             lastCol;

  // position of the pixel on the input this cycle
  always_comb begin
    curCol  = pixSof ? '0 : colCnt;
    curRow  = pixSof ? '0 : rowCnt;
    lastCol = (curCol == COL_W'(LINE_LEN - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      colCnt <= '0;
      rowCnt <= '0;
    end else if (pixValid) begin
      colCnt <= lastCol ? '0 : curCol + 1'b1;
      if (lastCol)
        rowCnt <= (curRow == '1) ? curRow : curRow + 1'b1;  // saturate on tall frames
      else
        rowCnt <= curRow;
    end
  end

  always_comb begin
    strobes.take   = pixValid;
    strobes.first  = pixValid & pixSof;
    strobes.border = (curRow < ROW_W'(2)) || (curCol < COL_W'(2));
    strobes.slot   = curRow[0];
    strobes.col    = COL_FIELD_W'(curCol);
  end

  // R9: the column after the last one is zero and the row has advanced
  a_r9_col_wrap : assert property (@(posedge clk) disable iff (!rst_n)
    (pixValid && curCol == COL_W'(LINE_LEN - 1)) |=> (colCnt == '0 && rowCnt != '0));

  // R8: a frame start puts the next pixel at column 1 of row 0
  a_r8_sof_restart : assert property (@(posedge clk) disable iff (!rst_n)
    (pixValid && pixSof) |=> (colCnt == COL_W'(1) && rowCnt == '0));

  // R3: idle cycles leave the position untouched
  a_r3_idle_hold : assert property (@(posedge clk) disable iff (!rst_n)
    !pixValid |=> ($stable(colCnt) && $stable(rowCnt)));
endmodule

// File: rtl/edge_linebuf.sv
module edge_linebuf #(
  parameter int PIX_W    = 8,
  parameter int LINE_LEN = 256
) (
  input  logic                        clk,
  input  logic                        en,
  input  logic                        slot,
  input  logic [$clog2(LINE_LEN)-1:0] addr,
  input  logic [PIX_W-1:0]            wrPix,
  output logic [PIX_W-1:0]            upPix,   // row r-1, same column
  output logic [PIX_W-1:0]            topPix   // row r-2, same column
);
  localparam int BANKS = 2;

  logic             slotD;
  logic [PIX_W-1:0] rdA, rdB;

  // Each bank reads before it writes: the bank owned by the current row
  // still returns the row two lines up at this address.
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [PIX_W-1:0] mem [LINE_LEN];
    logic [PIX_W-1:0] rd;
    always_ff @(posedge clk) begin
      if (en) begin
        if (slot == 1'(b)) mem[addr] <= wrPix;
        rd <= mem[addr];
      end
    end
  end

  assign rdA = g_bank[0].rd;
  assign rdB = g_bank[1].rd;

  always_ff @(posedge clk) begin
    if (en) slotD <= slot;
  end

  assign topPix = slotD ? rdB : rdA;
  assign upPix  = slotD ? rdA : rdB;
endmodule

// File: rtl/edge_kernel.sv
module edge_kernel #(
  parameter int PIX_W    = 8,
  parameter int ACC_W    = 12,
  parameter int TAPS [9] = '{-1, 0, 1, -1, 0, 1, -1, 0, 1}
) (
  input  logic                    clk,
  input  logic                    en,
  input  logic [8:0][PIX_W-1:0]   win,
  output logic signed [ACC_W-1:0] acc
);
  localparam int N_TAPS = 9;

  logic signed [ACC_W-1:0] prod [N_TAPS];
  logic signed [ACC_W-1:0] total;

  for (genvar t = 0; t < N_TAPS; t++) begin : g_tap
    localparam logic signed [ACC_W-1:0] CoefS = ACC_W'(TAPS[t]);
    logic signed [ACC_W-1:0] pixS;
    assign pixS    = ACC_W'({1'b0, win[t]});
    assign prod[t] = pixS * CoefS;
  end

  always_comb begin
    total = '0;
    for (int t = 0; t < N_TAPS; t++) total = total + prod[t];
  end

  always_ff @(posedge clk) begin
    if (en) acc <= total;
  end
endmodule

// File: rtl/edge_datapath.sv
module edge_datapath
  import edge_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int LINE_LEN = 256,
  parameter int ACC_W    = 12,
  parameter int KX [9]   = '{-1, 0, 1, -1, 0, 1, -1, 0, 1},
  parameter int KY [9]   = '{-1, -1, -1, 0, 0, 0, 1, 1, 1}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          strobes,
  input  logic [PIX_W-1:0] pixIn,
  output logic [PIX_W-1:0] outPix,
  output logic             outValid,
  output logic             outSof
);
  localparam int COL_W   = $clog2(LINE_LEN);
  localparam int PIX_MAX = (1 << PIX_W) - 1;

  logic [PIX_W-1:0]              topPix, upPix, pixD1;
  logic                          v1, v2, v3, f1, f2, f3, b1, b2, b3;
  logic [2:0][2:0][PIX_W-1:0]    win;      // [row][col], index 0 oldest
  logic [8:0][PIX_W-1:0]         winFlat;  // tap = 3*row + col
  logic signed [ACC_W-1:0]       gx, gy;
  logic [ACC_W-1:0]              absX, absY;
  logic [ACC_W:0]                sumXY;
  logic [PIX_W-1:0]              magSat;

  // stage 1: line RAM read and current pixel capture
  edge_linebuf #(.PIX_W(PIX_W), .LINE_LEN(LINE_LEN)) u_linebuf (
    .clk    (clk),
    .en     (strobes.take),
    .slot   (strobes.slot),
    .addr   (strobes.col[COL_W-1:0]),
    .wrPix  (pixIn),
    .upPix  (upPix),
    .topPix (topPix)
  );

  always_ff @(posedge clk) begin
    if (strobes.take) pixD1 <= pixIn;
  end

  // token flags travel alongside the data, one stage per clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {v1, v2, v3} <= '0;
      {f1, f2, f3} <= '0;
      {b1, b2, b3} <= '0;
    end else begin
      v1 <= strobes.take;  f1 <= strobes.first;  b1 <= strobes.border;
      v2 <= v1;            f2 <= f1;             b2 <= b1;
      v3 <= v2;            f3 <= f2;             b3 <= b2;
    end
  end

  // stage 2: the window moves one column per accepted pixel
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win <= '0;
    end else if (v1) begin
      for (int r = 0; r < 3; r++) begin
        win[r][0] <= win[r][1];
        win[r][1] <= win[r][2];
      end
      win[0][2] <= topPix;
      win[1][2] <= upPix;
      win[2][2] <= pixD1;
    end
  end

  assign winFlat = win;

  // stage 3: the two kernels
  edge_kernel #(.PIX_W(PIX_W), .ACC_W(ACC_W), .TAPS(KX)) u_kernX (
    .clk (clk), .en (v2), .win (winFlat), .acc (gx)
  );
  edge_kernel #(.PIX_W(PIX_W), .ACC_W(ACC_W), .TAPS(KY)) u_kernY (
    .clk (clk), .en (v2), .win (winFlat), .acc (gy)
  );

  // stage 4: magnitude, clip, border blanking
  always_comb begin
    absX   = gx[ACC_W-1] ? ACC_W'(-gx) : ACC_W'(gx);
    absY   = gy[ACC_W-1] ? ACC_W'(-gy) : ACC_W'(gy);
    sumXY  = {1'b0, absX} + {1'b0, absY};
    magSat = (sumXY > (ACC_W+1)'(PIX_MAX)) ? PIX_W'(PIX_MAX) : sumXY[PIX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outPix   <= '0;
      outValid <= 1'b0;
      outSof   <= 1'b0;
    end else begin
      outValid <= v3;
      outSof   <= v3 & f3;
      if (v3) outPix <= b3 ? '0 : magSat;
    end
  end

  // R3: no accepted pixel, no window movement
  a_r3_window_hold : assert property (@(posedge clk) disable iff (!rst_n)
    !v1 |=> $stable(win));

  // R7: a border token leaves as a zero result
  a_r7_border_zero : assert property (@(posedge clk) disable iff (!rst_n)
    (v3 && b3) |=> (outValid && outPix == '0));

  // R8: the frame marker never travels without a result
  a_r8_sof_with_valid : assert property (@(posedge clk) disable iff (!rst_n)
    outSof |-> outValid);
endmodule

// File: rtl/edge_prewitt.sv
module edge_prewitt
  import edge_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int LINE_LEN = 256,
  parameter int ROW_W    = 12,
  parameter int KX [9]   = '{-1, 0, 1, -1, 0, 1, -1, 0, 1},
  parameter int KY [9]   = '{-1, -1, -1, 0, 0, 0, 1, 1, 1}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] pixIn,
  input  logic             pixValid,
  input  logic             pixSof,
  output logic [PIX_W-1:0] outPix,
  output logic             outValid,
  output logic             outSof
);
  // accumulator width from the largest absolute coefficient sum, floor of 12
  function automatic int accBits();
    int sx = 0;
    int sy = 0;
    int worst;
    int bits;
    for (int i = 0; i < 9; i++) begin
      sx += (KX[i] < 0) ? -KX[i] : KX[i];
      sy += (KY[i] < 0) ? -KY[i] : KY[i];
    end
    worst = ((sx > sy) ? sx : sy) * ((1 << PIX_W) - 1);
    bits  = $clog2(worst + 1) + 1;
    return (bits < 12) ? 12 : bits;
  endfunction

  localparam int ACC_W = accBits();

  strobe_t strobes;

  edge_ctrl #(.LINE_LEN(LINE_LEN), .ROW_W(ROW_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .pixValid (pixValid),
    .pixSof   (pixSof),
    .strobes  (strobes)
  );

  edge_datapath #(
    .PIX_W(PIX_W), .LINE_LEN(LINE_LEN), .ACC_W(ACC_W), .KX(KX), .KY(KY)
  ) u_datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .pixIn    (pixIn),
    .outPix   (outPix),
    .outValid (outValid),
    .outSof   (outSof)
  );
endmodule

// File: tb/edge_prewitt_bench.sv
module edge_prewitt_bench;
  localparam int LINE   = 256;
  localparam int ROWS   = 8;
  localparam int MAXPIX = ROWS * LINE;
  localparam int LAT    = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pixIn = '0;
  logic       pixValid = 1'b0;
  logic       pixSof = 1'b0;
  logic [7:0] outPix;
  logic       outValid, outSof;

  always #4 clk = ~clk;  // 125 MHz

  edge_prewitt u_edge_prewitt (
    .clk (clk), .rst_n (rst_n), .pixIn (pixIn), .pixValid (pixValid),
    .pixSof (pixSof), .outPix (outPix), .outValid (outValid), .outSof (outSof)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int seed = 7;
  bit finished = 0;

  logic [7:0] img [ROWS][LINE];
  logic [7:0] cap [MAXPIX];
  bit         capSof [MAXPIX];
  int         capCyc [MAXPIX];
  int         inCyc [MAXPIX];
  int         capCnt = 0;
  int         inCnt = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (outValid && capCnt < MAXPIX) begin
      cap[capCnt]    = outPix;
      capSof[capCnt] = outSof;
      capCyc[capCnt] = cyc;
      capCnt++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pattern(input int kind, input int r, input int c);
    case (kind)
      0:       return 77;
      1:       return (c < 100) ? 10 : 30;
      2:       return (r < 4) ? 200 : 190;
      3:       return (c < 128) ? 0 : 255;
      default: return (r * 37 + c * 11 + (r * c) % 7) & 255;
    endcase
  endfunction

  task automatic setImg(input int kind);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < LINE; c++) img[r][c] = 8'(pattern(kind, r, c));
  endtask

  // independent reference: Prewitt pair, |x|+|y|, clip, zero border
  function automatic int refMag(input int r, input int c);
    int gx = 0;
    int gy = 0;
    int s;
    if (r < 2 || c < 2) return 0;
    for (int dr = 0; dr < 3; dr++)
      for (int dc = 0; dc < 3; dc++) begin
        int p;
        p = img[r-2+dr][c-2+dc];
        gx += (dc - 1) * p;
        gy += (dr - 1) * p;
      end
    s = (gx < 0 ? -gx : gx) + (gy < 0 ? -gy : gy);
    return (s > 255) ? 255 : s;
  endfunction

  task automatic idleCycle();
    @(negedge clk);
    seed     = seed * 1103515245 + 12345;
    pixValid = 1'b0;
    pixSof   = 1'b1;           // junk marker, must be ignored
    pixIn    = seed[15:8];     // junk data, must be ignored
  endtask

  task automatic driveFrame(input int rows, input bit gaps);
    capCnt = 0;
    inCnt  = 0;
    for (int r = 0; r < rows; r++)
      for (int c = 0; c < LINE; c++) begin
        if (gaps) begin
          seed = seed * 1103515245 + 12345;
          if (seed[18:17] == 2'd0)
            for (int g = 0; g <= int'(seed[4:3]); g++) idleCycle();
        end
        @(negedge clk);
        pixValid = 1'b1;
        pixSof   = (r == 0 && c == 0);
        pixIn    = img[r][c];
        inCyc[inCnt] = cyc;
        inCnt++;
      end
    @(negedge clk);
    pixValid = 1'b0;
    pixSof   = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic compareFrame(input string tag);
    int n;
    int bad = -1;
    int badLat = -1;
    int sofs = 0;
    check(capCnt == inCnt, "R2 output count", capCnt, inCnt);
    n = (capCnt < inCnt) ? capCnt : inCnt;
    for (int k = 0; k < n; k++) begin
      if (bad < 0 && int'(cap[k]) != refMag(k / LINE, k % LINE)) bad = k;
      if (badLat < 0 && capCyc[k] - inCyc[k] != LAT) badLat = k;
      if (capSof[k]) sofs++;
    end
    check(bad < 0, tag, (bad < 0) ? 0 : int'(cap[bad]),
          (bad < 0) ? 0 : refMag(bad / LINE, bad % LINE));
    check(badLat < 0, "R2 latency", (badLat < 0) ? LAT : capCyc[badLat] - inCyc[badLat], LAT);
    check(n > 0 && capSof[0] && sofs == 1, "R8 outSof on first result only", sofs, 1);
  endtask

  task automatic testReset();
    rst_n    = 1'b0;
    pixValid = 1'b1;
    pixIn    = 8'hA5;
    repeat (3) @(negedge clk);
    check(!outValid && outPix == 0, "R1 in reset", {outValid, outPix}, 0);
    pixValid = 1'b0;
    rst_n    = 1'b1;
    repeat (5) @(negedge clk);
    check(!outValid && outPix == 0, "R1 after reset", {outValid, outPix}, 0);
  endtask

  task automatic testFlat();
    setImg(0);
    driveFrame(4, 1'b0);
    compareFrame("R6 flat frame");
  endtask

  task automatic testVertical();
    setImg(1);
    driveFrame(4, 1'b0);
    compareFrame("R4 column step");
    check(int'(cap[2 * LINE + 100]) == 60, "R4 step magnitude", cap[2 * LINE + 100], 60);
  endtask

  task automatic testHorizontal();
    setImg(2);
    driveFrame(6, 1'b0);
    compareFrame("R5 row step");
    check(int'(cap[5 * LINE + 50]) == 30, "R5 step magnitude", cap[5 * LINE + 50], 30);
  endtask

  task automatic testSaturate();
    setImg(3);
    driveFrame(4, 1'b0);
    compareFrame("R6 saturation");
    check(int'(cap[3 * LINE + 128]) == 255, "R6 clipped", cap[3 * LINE + 128], 255);
  endtask

  task automatic testGaps();
    setImg(4);
    driveFrame(6, 1'b1);
    compareFrame("R3 gapped stream");
  endtask

  task automatic testBorder();
    int nz = 0;
    setImg(4);
    driveFrame(5, 1'b0);
    compareFrame("R9 multi-row ramp");
    for (int k = 0; k < capCnt; k++)
      if (((k / LINE) < 2 || (k % LINE) < 2) && cap[k] != 0) nz++;
    check(nz == 0, "R7 border zeros", nz, 0);
    check(int'(cap[2 * LINE + 2]) == refMag(2, 2) && refMag(2, 2) != 0,
          "R7 first interior", cap[2 * LINE + 2], refMag(2, 2));
  endtask

  task automatic testRestart();
    setImg(4);
    // stop part-way through the third line of a frame
    for (int k = 0; k < 2 * LINE + 44; k++) begin
      @(negedge clk);
      pixValid = 1'b1;
      pixSof   = (k == 0);
      pixIn    = 8'(k * 13);
    end
    @(negedge clk);
    pixValid = 1'b0;
    pixSof   = 1'b0;
    repeat (10) @(negedge clk);
    driveFrame(5, 1'b0);
    compareFrame("R8 restart mid-line");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    testReset();
    testFlat();
    testVertical();
    testHorizontal();
    testSaturate();
    testGaps();
    testBorder();
    testRestart();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule